// File: doc/BRIEF.md
# Program Memory Overlay Access Controller

This block sits between a processor core's program-memory port and two storage paths: an on-chip program RAM of 16K words and an external memory bus. Every word is 24 bits wide. For each core request it decodes the 14-bit word address. The lower 8K always goes to the on-chip RAM. The upper 8K goes either to the on-chip RAM or to one of two 8K external overlay segments. A small overlay register picks which one.

On-chip accesses complete in the cycle they are issued and never stall the core. An external overlay access stalls the core for a programmable number of wait cycles, each one clock long. The wait count comes from a 3-bit wait-state register that resets to seven. The controller holds the external strobe and address steady for the whole access. It captures read data in the last strobe cycle and returns it to the core on the next cycle.

The controller is built around three states. `ST_IDLE` accepts requests. `ST_XWAIT` counts the wait states that remain. `ST_XDONE` is the final strobe cycle, in which the stall is already released. The transitions are:
- IDLE→IDLE when there is no request, the request is on-chip, or the request is external with zero waits.
- IDLE→XDONE when the request is external with one wait.
- IDLE→XWAIT when the request is external with more than one wait.
- XWAIT→XWAIT while the count is non-zero.
- XWAIT→XDONE when the count reaches zero.
- XDONE→IDLE always.

Top module: `pmem_overlay_ctrl`

## Requirements
- R1: An address with bit 13 clear is always served by the on-chip RAM, whatever the overlay setting. `iram_en` is high in the request cycle, `pm_stall` stays low, and no external strobe is raised.
- R2: An address with bit 13 set is served by the on-chip RAM, with no stall, when the overlay register holds 0.
- R3: With overlay value 1 or 2, an upper-half address goes to the external bus. `ext_addr` carries address bits 12:0. `ext_seg` is 0 for overlay value 1 and 1 for overlay value 2. `iram_en` stays low.
- R4: After reset the wait-state register holds 7, so the first external access stalls the core for exactly 7 cycles.
- R5: With a wait value N, `pm_stall` is high for exactly N cycles starting with the cycle in which the strobe rises. The strobe is held for N+1 cycles. With N=0 there is no stall and the strobe lasts one cycle.
- R6: Read data returns with `pm_rvalid` one cycle after the access completes. On-chip reads return `iram_rdata`. External reads return `ext_rdata` as sampled in strobe cycle N+1.
- R7: An external write drives `ext_wr` with `ext_wdata` equal to the core's write data. An external write raises neither `ext_rd` nor `pm_rvalid`.
- R8: `ext_rd` and `ext_wr` are never high together, and neither is high without an external access.
- R9: The overlay register resets to 0. A write of the unused code 3 leaves the register unchanged.
- R10: An overlay write that arrives while `pm_stall` is high does not affect the running access. It takes effect once that access completes.
- R11: While `pm_stall` is high, the next cycle keeps `ext_addr`, `ext_seg` and the active strobe unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_req | input | 1 | Core program-memory request |
| pm_we | input | 1 | Request is a write |
| pm_addr | input | 14 | Word address |
| pm_wdata | input | 24 | Write data |
| pm_rdata | output | 24 | Read data returned to the core |
| pm_rvalid | output | 1 | Read data valid |
| pm_stall | output | 1 | Core must hold its request |
| ovl_wr | input | 1 | Overlay register write strobe |
| ovl_wdata | input | 2 | Overlay code: 0 on-chip, 1 segment one, 2 segment two |
| ws_wr | input | 1 | Wait-state register write strobe |
| ws_wdata | input | 3 | Wait states per overlay access |
| iram_en | output | 1 | On-chip RAM access enable |
| iram_we | output | 1 | On-chip RAM write enable |
| iram_addr | output | 14 | On-chip RAM word address |
| iram_wdata | output | 24 | On-chip RAM write data |
| iram_rdata | input | 24 | On-chip RAM read data, one cycle after enable |
| ext_addr | output | 13 | Offset within the overlay segment |
| ext_seg | output | 1 | Overlay segment select |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_wdata | output | 24 | External write data |
| ext_rdata | input | 24 | External read data |

## Verification
The assertions take for granted that the core holds `pm_req` and its address, direction and data steady while `pm_stall` is high. They also assume the core issues no new request in the cycle in which a stalled access completes. The on-chip RAM is assumed to return data on the cycle after `iram_en`. The bench drives all core inputs on the falling edge. Each task holds a request until the stall drops and then clears it, and the bench releases the request before issuing the next one. The only input that changes during a stall is the overlay write used to exercise deferral.

// File: rtl/pmo_pkg.sv
package pmo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XWAIT = 2'd1,
        ST_XDONE = 2'd2
    } pmo_state_e;

    localparam logic [1:0] OVL_ONCHIP = 2'd0;
    localparam logic [1:0] OVL_SEG_A  = 2'd1;
    localparam logic [1:0] OVL_SEG_B  = 2'd2;
    localparam logic [1:0] OVL_UNUSED = 2'd3;
endpackage

// File: rtl/pmo_decode.sv
module pmo_decode
    import pmo_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        ovl,
    output logic              is_ext,
    output logic              seg,
    output logic [ADDR_W-2:0] offset
);
    logic upper;

    always_comb begin
        upper  = addr[ADDR_W-1];
        offset = addr[ADDR_W-2:0];
        is_ext = upper && ((ovl == OVL_SEG_A) || (ovl == OVL_SEG_B));
        seg    = (ovl == OVL_SEG_B);
    end
endmodule

// File: rtl/pmo_cfg_regs.sv
module pmo_cfg_regs
    import pmo_pkg::*;
#(
    parameter int              WS_W     = 3,
    parameter logic [WS_W-1:0] WS_RESET = 3'd7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            ovl_wr,
    input  logic [1:0]      ovl_wdata,
    input  logic            ws_wr,
    input  logic [WS_W-1:0] ws_wdata,
    output logic [1:0]      ovl_q,
    output logic [WS_W-1:0] ws_q
);
    logic [1:0] pend_q;
    logic       pend_v_q;
    logic       ovl_ok;

    assign ovl_ok = ovl_wr && (ovl_wdata != OVL_UNUSED);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovl_q    <= OVL_ONCHIP;
            pend_q   <= OVL_ONCHIP;
            pend_v_q <= 1'b0;
        end else if (!hold) begin
            if (ovl_ok) begin
                ovl_q <= ovl_wdata;
            end else if (pend_v_q) begin
                ovl_q <= pend_q;
            end
            pend_v_q <= 1'b0;
        end else if (ovl_ok) begin
            pend_q   <= ovl_wdata;
            pend_v_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q <= WS_RESET;
        end else if (ws_wr) begin
            ws_q <= ws_wdata;
        end
    end

    a_r9_no_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_q != OVL_UNUSED);

    a_r10_no_change_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ovl_q) |-> !$past(hold));
endmodule

// File: rtl/pmo_wait_fsm.sv
module pmo_wait_fsm
    import pmo_pkg::*;
#(
    parameter int WS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WS_W-1:0] ws,
    output logic            stall,
    output logic            strobe_on,
    output logic            busy,
    output logic            done
);
    localparam logic [WS_W-1:0] WS_ONE = WS_W'(1);
    localparam logic [WS_W-1:0] WS_TWO = WS_W'(2);

    pmo_state_e      state_q, state_d;
    logic [WS_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && (ws == WS_ONE)) begin
                    state_d = ST_XDONE;
                end else if (start && (ws > WS_ONE)) begin
                    state_d = ST_XWAIT;
                    cnt_d   = ws - WS_TWO;
                end
            end
            ST_XWAIT: begin
                if (cnt_q == '0) begin
                    state_d = ST_XDONE;
                end else begin
                    cnt_d = cnt_q - WS_ONE;
                end
            end
            ST_XDONE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        stall     = 1'b0;
        strobe_on = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                strobe_on = start;
                stall     = start && (ws != '0);
                done      = start && (ws == '0);
            end
            ST_XWAIT: begin
                strobe_on = 1'b1;
                stall     = 1'b1;
                busy      = 1'b1;
            end
            ST_XDONE: begin
                strobe_on = 1'b1;
                busy      = 1'b1;
                done      = 1'b1;
            end
            default: begin
                stall = 1'b0;
            end
        endcase
    end

    a_r5_wait_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XWAIT && cnt_q == '0) |=> (state_q == ST_XDONE));

    a_r5_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XDONE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pmem_overlay_ctrl.sv
module pmem_overlay_ctrl
    import pmo_pkg::*;
#(
    parameter int              ADDR_W   = 14,
    parameter int              DATA_W   = 24,
    parameter int              WS_W     = 3,
    parameter logic [WS_W-1:0] WS_RESET = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pm_req,
    input  logic              pm_we,
    input  logic [ADDR_W-1:0] pm_addr,
    input  logic [DATA_W-1:0] pm_wdata,
    output logic [DATA_W-1:0] pm_rdata,
    output logic              pm_rvalid,
    output logic              pm_stall,
    input  logic              ovl_wr,
    input  logic [1:0]        ovl_wdata,
    input  logic              ws_wr,
    input  logic [WS_W-1:0]   ws_wdata,
    output logic              iram_en,
    output logic              iram_we,
    output logic [ADDR_W-1:0] iram_addr,
    output logic [DATA_W-1:0] iram_wdata,
    input  logic [DATA_W-1:0] iram_rdata,
    output logic [ADDR_W-2:0] ext_addr,
    output logic              ext_seg,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata
);
    localparam int OFF_W = ADDR_W - 1;

    logic [1:0]        ovl_q;
    logic [WS_W-1:0]   ws_q;
    logic              dec_ext, dec_seg;
    logic [OFF_W-1:0]  dec_off;
    logic              start, stall, strobe_on, busy, done;
    logic [OFF_W-1:0]  x_off_q;
    logic              x_seg_q, x_we_q;
    logic [DATA_W-1:0] x_wdata_q, xcap_q;
    logic              rsrc_ext_q, rvalid_q;
    logic              cur_we;

    pmo_cfg_regs #(.WS_W(WS_W), .WS_RESET(WS_RESET)) u_cfg (
        .clk(clk), .rst_n(rst_n), .hold(stall),
        .ovl_wr(ovl_wr), .ovl_wdata(ovl_wdata),
        .ws_wr(ws_wr), .ws_wdata(ws_wdata),
        .ovl_q(ovl_q), .ws_q(ws_q)
    );

    pmo_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(pm_addr), .ovl(ovl_q),
        .is_ext(dec_ext), .seg(dec_seg), .offset(dec_off)
    );

    assign start = pm_req && dec_ext && !busy;

    pmo_wait_fsm #(.WS_W(WS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .ws(ws_q),
        .stall(stall), .strobe_on(strobe_on), .busy(busy), .done(done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_off_q   <= '0;
            x_seg_q   <= 1'b0;
            x_we_q    <= 1'b0;
            x_wdata_q <= '0;
        end else if (start) begin
            x_off_q   <= dec_off;
            x_seg_q   <= dec_seg;
            x_we_q    <= pm_we;
            x_wdata_q <= pm_wdata;
        end
    end

    always_comb begin
        cur_we    = busy ? x_we_q : pm_we;
        ext_addr  = busy ? x_off_q : dec_off;
        ext_seg   = busy ? x_seg_q : dec_seg;
        ext_wdata = busy ? x_wdata_q : pm_wdata;
        ext_rd    = strobe_on && !cur_we;
        ext_wr    = strobe_on && cur_we;
        pm_stall  = stall;
    end

    always_comb begin
        iram_en    = pm_req && !dec_ext && !busy;
        iram_we    = iram_en && pm_we;
        iram_addr  = pm_addr;
        iram_wdata = pm_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xcap_q     <= '0;
            rsrc_ext_q <= 1'b0;
            rvalid_q   <= 1'b0;
        end else begin
            if (done && !cur_we) begin
                xcap_q <= ext_rdata;
            end
            rsrc_ext_q <= done;
            rvalid_q   <= (iram_en && !pm_we) || (done && !cur_we);
        end
    end

    assign pm_rvalid = rvalid_q;
    assign pm_rdata  = rsrc_ext_q ? xcap_q : iram_rdata;

    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && ext_wr));

    a_r1_onchip_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        iram_en |-> !pm_stall);

    a_r5_stall_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pm_stall |-> (ext_rd || ext_wr));

    a_r11_hold_bus: assert property (@(posedge clk) disable iff (!rst_n)
        pm_stall |=> ($stable(ext_addr) && $stable(ext_seg) && $stable(ext_rd) && $stable(ext_wr)));

    a_r7_write_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_wr && !pm_stall) |=> !pm_rvalid);

    a_r3_ext_not_onchip: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd || ext_wr) |-> !iram_en);
endmodule

// File: tb/pmem_overlay_ctrl_test.sv
module pmem_overlay_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pm_req = 1'b0, pm_we = 1'b0;
    logic [13:0] pm_addr = '0;
    logic [23:0] pm_wdata = '0;
    logic [23:0] pm_rdata;
    logic        pm_rvalid, pm_stall;
    logic        ovl_wr = 1'b0;
    logic [1:0]  ovl_wdata = '0;
    logic        ws_wr = 1'b0;
    logic [2:0]  ws_wdata = '0;
    logic        iram_en, iram_we;
    logic [13:0] iram_addr;
    logic [23:0] iram_wdata, iram_rdata;
    logic [12:0] ext_addr;
    logic        ext_seg, ext_rd, ext_wr;
    logic [23:0] ext_wdata, ext_rdata;
    logic [23:0] ir_q = '0;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    function automatic logic [23:0] imem_fn(input logic [13:0] a);
        return {10'h2A5, a};
    endfunction

    function automatic logic [23:0] xmem_fn(input logic s, input logic [12:0] o);
        return {3'b101, s, 7'h11, o};
    endfunction

    always @(posedge clk) if (iram_en && !iram_we) ir_q <= imem_fn(iram_addr);
    assign iram_rdata = ir_q;
    assign ext_rdata  = xmem_fn(ext_seg, ext_addr);

    pmem_overlay_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pm_req(pm_req), .pm_we(pm_we),
        .pm_addr(pm_addr), .pm_wdata(pm_wdata), .pm_rdata(pm_rdata),
        .pm_rvalid(pm_rvalid), .pm_stall(pm_stall),
        .ovl_wr(ovl_wr), .ovl_wdata(ovl_wdata), .ws_wr(ws_wr), .ws_wdata(ws_wdata),
        .iram_en(iram_en), .iram_we(iram_we), .iram_addr(iram_addr),
        .iram_wdata(iram_wdata), .iram_rdata(iram_rdata),
        .ext_addr(ext_addr), .ext_seg(ext_seg), .ext_rd(ext_rd), .ext_wr(ext_wr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_ovl(input logic [1:0] v);
        @(negedge clk); ovl_wr = 1'b1; ovl_wdata = v;
        @(negedge clk); ovl_wr = 1'b0;
    endtask

    task automatic set_ws(input logic [2:0] v);
        @(negedge clk); ws_wr = 1'b1; ws_wdata = v;
        @(negedge clk); ws_wr = 1'b0;
    endtask

    task automatic int_access(input logic [13:0] a, input logic we,
                              input logic [23:0] wd, input string req);
        @(negedge clk);
        pm_req = 1'b1; pm_we = we; pm_addr = a; pm_wdata = wd;
        #1;
        chk(iram_en == 1'b1, req, "iram_en", 32'(iram_en), 1);
        chk(pm_stall == 1'b0, req, "stall on on-chip", 32'(pm_stall), 0);
        chk(!ext_rd && !ext_wr, req, "ext strobe on on-chip", {30'd0, ext_rd, ext_wr}, 0);
        chk(iram_addr == a, req, "iram_addr", 32'(iram_addr), 32'(a));
        chk(iram_we == we, req, "iram_we", 32'(iram_we), 32'(we));
        if (we) chk(iram_wdata == wd, req, "iram_wdata", 32'(iram_wdata), 32'(wd));
        @(negedge clk);
        pm_req = 1'b0; pm_we = 1'b0;
        #1;
        chk(pm_rvalid == !we, "R6", "rvalid after on-chip", 32'(pm_rvalid), 32'(!we));
        if (!we) chk(pm_rdata == imem_fn(a), "R6", "on-chip rdata", 32'(pm_rdata), 32'(imem_fn(a)));
    endtask

    task automatic ext_access(input logic [13:0] a, input logic we, input logic [23:0] wd,
                              input int exp_n, input logic exp_seg, input string req,
                              input bit defer_to_onchip);
        int n;
        logic [12:0] a0;
        @(negedge clk);
        pm_req = 1'b1; pm_we = we; pm_addr = a; pm_wdata = wd;
        #1;
        n = 0;
        a0 = ext_addr;
        while (pm_stall && n < 20) begin
            chk(ext_addr == a0 && ext_seg == exp_seg, "R11", "bus held in stall",
                {18'd0, ext_seg, ext_addr}, {18'd0, exp_seg, a0});
            chk(iram_en == 1'b0, "R3", "iram_en on overlay", 32'(iram_en), 0);
            n++;
            @(negedge clk);
            ovl_wr = 1'b0;
            if (defer_to_onchip && n == 1) begin
                ovl_wr = 1'b1; ovl_wdata = 2'd0;
            end
            #1;
        end
        ovl_wr = 1'b0;
        chk(n == exp_n, req, "stall cycles", 32'(n), 32'(exp_n));
        chk(ext_seg == exp_seg, "R3", "ext_seg", 32'(ext_seg), 32'(exp_seg));
        chk(ext_addr == a[12:0], "R3", "ext_addr", 32'(ext_addr), 32'(a[12:0]));
        if (we) begin
            chk(ext_wr && !ext_rd, "R7", "write strobe", {30'd0, ext_rd, ext_wr}, 1);
            chk(ext_wdata == wd, "R7", "ext_wdata", 32'(ext_wdata), 32'(wd));
        end else begin
            chk(ext_rd && !ext_wr, "R8", "read strobe", {30'd0, ext_rd, ext_wr}, 2);
        end
        @(negedge clk);
        pm_req = 1'b0; pm_we = 1'b0;
        #1;
        chk(!ext_rd && !ext_wr, "R5", "strobe drops after N+1", {30'd0, ext_rd, ext_wr}, 0);
        chk(pm_rvalid == !we, we ? "R7" : "R6", "rvalid after overlay", 32'(pm_rvalid), 32'(!we));
        if (!we) chk(pm_rdata == xmem_fn(exp_seg, a[12:0]), "R6", "overlay rdata",
                     32'(pm_rdata), 32'(xmem_fn(exp_seg, a[12:0])));
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(pm_stall == 1'b0, "R8", "stall after reset", 32'(pm_stall), 0);
        chk(!ext_rd && !ext_wr, "R8", "strobes idle", {30'd0, ext_rd, ext_wr}, 0);
        chk(pm_rvalid == 1'b0, "R6", "rvalid after reset", 32'(pm_rvalid), 0);
        int_access(14'h2040, 1'b0, '0, "R9");
    endtask

    task automatic t_default_wait;
        set_ovl(2'd1);
        ext_access(14'h2010, 1'b0, '0, 7, 1'b0, "R4", 1'b0);
    endtask

    task automatic t_lower;
        int_access(14'h0123, 1'b0, '0, "R1");
        int_access(14'h1FFF, 1'b1, 24'hC0FFEE, "R1");
    endtask

    task automatic t_unused_code;
        set_ovl(2'd3);
        ext_access(14'h3FFF, 1'b0, '0, 7, 1'b0, "R9", 1'b0);
    endtask

    task automatic t_upper_onchip;
        set_ovl(2'd0);
        int_access(14'h2005, 1'b0, '0, "R2");
    endtask

    task automatic t_zero_wait;
        set_ws(3'd0);
        set_ovl(2'd2);
        ext_access(14'h2ABC, 1'b0, '0, 0, 1'b1, "R5", 1'b0);
    endtask

    task automatic t_three_wait;
        set_ws(3'd3);
        set_ovl(2'd1);
        ext_access(14'h2001, 1'b0, '0, 3, 1'b0, "R5", 1'b0);
    endtask

    task automatic t_ext_write;
        set_ws(3'd2);
        set_ovl(2'd2);
        ext_access(14'h2222, 1'b1, 24'h5A5A5A, 2, 1'b1, "R7", 1'b0);
    endtask

    task automatic t_defer;
        set_ws(3'd4);
        set_ovl(2'd1);
        ext_access(14'h2100, 1'b0, '0, 4, 1'b0, "R10", 1'b1);
        int_access(14'h2100, 1'b0, '0, "R10");
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_default_wait();
        t_lower();
        t_unused_code();
        t_upper_onchip();
        t_zero_wait();
        t_three_wait();
        t_ext_write();
        t_defer();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule